// File: doc/BRIEF.md
# Synchronous USB FIFO Loopback Bridge

This block sits in the FPGA next to a USB bridge chip whose data side is set to a synchronous, byte-wide parallel FIFO mode. It runs entirely on the clock that the chip supplies (nominally 60 MHz). Every byte moves on a rising edge of that clock. The block pulls bytes that the host has sent, using the chip's read handshake, and parks them in a small local buffer. It then hands the same bytes back to the host, in the same order, using the chip's write handshake. The result is a host-visible echo path, useful for bring-up and for checking link integrity.

All handshake lines are active low.

Inputs from the chip:
- `rxf_n` low means the chip holds at least one received byte.
- `txe_n` low means the chip's transmit FIFO has space.

Outputs to the chip:
- `oe_n` low turns the shared bus toward the FPGA, so the chip drives it.
- `rd_n` low pulls one byte per clock.
- `wr_n` low pushes one byte per clock.
- `siwu_n` is the send-immediate/wake line. It is unused and held high.

Control is a five-state machine.

States:
- `ST_IDLE`: bus released, no strobe.
- `ST_TURN`: `oe_n` low, `rd_n` high. This is the bus turnaround cycle.
- `ST_READ`: `oe_n` and `rd_n` both low. Bytes are streamed in.
- `ST_CLOSE`: `rd_n` back high, `oe_n` still low for one cycle.
- `ST_WRITE`: `wr_n` low and the FPGA drives the buffer head onto the bus.

Transitions:
- *open-read*: IDLE→TURN when `rxf_n` is low and the buffer is not full.
- *start-read*: TURN→READ under the same condition. *abort-turn*: TURN→IDLE otherwise.
- *stop-read*: READ→CLOSE when `rxf_n` is high at an edge, or when the byte taken at that edge fills the buffer.
- *release*: CLOSE→IDLE, unconditional.
- *start-write*: IDLE→WRITE when the buffer is not empty, `txe_n` is low and no read can start.
- *stall-write*: WRITE→IDLE when `txe_n` is high at an edge.
- *drain-done*: WRITE→IDLE when the byte taken at that edge was the last one held.

Top module: `usb_fifo_loopback`

## Requirements
- R1: While reset is held, `oe_n`, `rd_n` and `wr_n` are high (1). `siwu_n` is high at all times.
- R2: `rd_n` goes low only when `oe_n` was already low in the previous cycle, and `rd_n` is never low while `oe_n` is high.
- R3: A byte is taken from the chip exactly on the edges where `rxf_n` and `rd_n` are both low. After an edge with `rd_n` low and `rxf_n` high, `rd_n` is high while `oe_n` stays low, and one cycle later `oe_n` is high.
- R4: A byte is handed to the chip exactly on the edges where `txe_n` and `wr_n` are both low. After an edge with `wr_n` low and `txe_n` high, `wr_n` is high, and the byte that was not taken is presented again on the next write.
- R5: `oe_n` and `wr_n` are never low together, and the FPGA drives the data bus only while `wr_n` is low.
- R6: Every byte taken is returned exactly once, in the order it was taken.
- R7: The buffer holds at most DEPTH bytes (default 16). In any cycle where it holds DEPTH bytes, `rd_n` is high.
- R8: A write burst begins only from a cycle with `oe_n` high, `txe_n` low, at least one byte held, and either `rxf_n` high or the buffer full. Reading has priority.
- R9: `wr_n` is low only while at least one byte is held. After the edge that takes the last held byte, `wr_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the USB chip; all transfers on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxf_n | input | 1 | Low: chip has received data available |
| txe_n | input | 1 | Low: chip transmit FIFO can accept data |
| oe_n | output | 1 | Low: chip drives the data bus |
| rd_n | output | 1 | Low: read one byte per clock from the chip |
| wr_n | output | 1 | Low: write one byte per clock to the chip |
| siwu_n | output | 1 | Send-immediate/wake, held high |
| data | inout | DATA_W (8) | Shared bidirectional data bus |

## Verification
A corrupted buffer pointer or occupancy count shows up at the ports as a wrong, missing or repeated byte on the write side. This happens on the very next write burst, so an in-order comparison of every returned byte against the sequence the modelled chip handed over catches it within one burst. A wrong state encoding or a bad transition is visible within one or two cycles as a handshake violation:
- `rd_n` falling without an earlier `oe_n` low,
- a strobe that stays low after its status flag went high,
- `oe_n` and `wr_n` low together.

The bench checks these cycle by cycle, using random stalls on both status flags and directed cases for buffer full, a single byte, and back-pressure that holds the buffer full.

// File: rtl/usb_lb_pkg.sv
`timescale 1ns/1ps
package usb_lb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_CLOSE,
        ST_WRITE
    } lb_state_e;

endpackage

// File: rtl/usb_lb_fifo.sv
`timescale 1ns/1ps
module usb_lb_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            din,
    input  logic                         pop,
    output logic [DATA_W-1:0]            dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);

endmodule

// File: rtl/usb_lb_ctrl.sv
`timescale 1ns/1ps
module usb_lb_ctrl
    import usb_lb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxf_n,
    input  logic          txe_n,
    input  logic [CW-1:0] level,
    input  logic          full,
    input  logic          empty,
    output logic          push,
    output logic          pop,
    output logic          oe_n,
    output logic          rd_n,
    output logic          wr_n
);
    lb_state_e state, state_nx;

    logic can_read, last_slot, last_byte;

    assign can_read  = !rxf_n && !full;
    assign last_slot = (level == CW'(DEPTH-1));
    assign last_byte = (level == CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (can_read)                  state_nx = ST_TURN;   // open-read
                else if (!empty && !txe_n)     state_nx = ST_WRITE;  // start-write
            end
            ST_TURN: begin
                if (can_read) state_nx = ST_READ;                    // start-read
                else          state_nx = ST_IDLE;                    // abort-turn
            end
            ST_READ: begin
                if (rxf_n || last_slot) state_nx = ST_CLOSE;         // stop-read
            end
            ST_CLOSE: state_nx = ST_IDLE;                            // release
            ST_WRITE: begin
                if (txe_n)          state_nx = ST_IDLE;              // stall-write
                else if (last_byte) state_nx = ST_IDLE;              // drain-done
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        oe_n = 1'b1;
        rd_n = 1'b1;
        wr_n = 1'b1;
        push = 1'b0;
        pop  = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_TURN:  oe_n = 1'b0;
            ST_READ: begin
                oe_n = 1'b0;
                rd_n = 1'b0;
                push = !rxf_n;
            end
            ST_CLOSE: oe_n = 1'b0;
            ST_WRITE: begin
                wr_n = 1'b0;
                pop  = !txe_n;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usb_fifo_loopback.sv
`timescale 1ns/1ps
module usb_fifo_loopback #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxf_n,
    input  logic              txe_n,
    output logic              oe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              siwu_n,
    inout  wire  [DATA_W-1:0] data
);
    localparam int CW = $clog2(DEPTH+1);

    logic              push, pop, full, empty, bus_drv;
    logic [CW-1:0]     fifo_level;
    logic [DATA_W-1:0] head;

    usb_lb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (data),
        .pop   (pop),
        .dout  (head),
        .level (fifo_level),
        .full  (full),
        .empty (empty)
    );

    usb_lb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .rxf_n (rxf_n),
        .txe_n (txe_n),
        .level (fifo_level),
        .full  (full),
        .empty (empty),
        .push  (push),
        .pop   (pop),
        .oe_n  (oe_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n)
    );

    assign bus_drv = !wr_n;
    assign data    = bus_drv ? head : {DATA_W{1'bz}};
    assign siwu_n  = 1'b1;

endmodule

// File: rtl/usb_lb_checker.sv
`timescale 1ns/1ps
module usb_lb_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH+1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rxf_n,
    input logic          txe_n,
    input logic          oe_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          siwu_n,
    input logic [CW-1:0] level,
    input logic          drv_en
);
    AST_SIWU_HIGH: assert property (@(posedge clk) siwu_n);                                              // R1
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (oe_n && rd_n && wr_n));                  // R1
    AST_OE_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_n) |-> $past(!oe_n)); // R2
    AST_RD_INSIDE_OE: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !oe_n);             // R2
    AST_RXF_STOPS_RD: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && rxf_n) |=> (rd_n && !oe_n)); // R3
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_n) |=> oe_n);          // R3
    AST_TXE_STOPS_WR: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && txe_n) |=> wr_n);   // R4
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && drv_en));         // R5
    AST_NO_OE_WR: assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && !wr_n));               // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) level <= CW'(DEPTH));          // R7
    AST_FULL_STOPS_RD: assert property (@(posedge clk) disable iff (!rst_n) (level == CW'(DEPTH)) |-> rd_n); // R7
    AST_WR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_n) |-> $past(oe_n)); // R8
    AST_WR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> (level != '0));      // R9
    AST_LAST_STOPS_WR: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !txe_n && level == CW'(1)) |=> wr_n); // R9
endmodule

bind usb_fifo_loopback usb_lb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxf_n  (rxf_n),
    .txe_n  (txe_n),
    .oe_n   (oe_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .siwu_n (siwu_n),
    .level  (fifo_level),
    .drv_en (bus_drv)
);

// File: tb/usb_fifo_loopback_test.sv
`timescale 1ns/1ps
module usb_fifo_loopback_test;
    localparam int CLK_PERIOD = 16;
    localparam int DEPTH      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxf_n = 1'b1, txe_n = 1'b1;
    logic oe_n, rd_n, wr_n, siwu_n;
    logic chip_drv = 1'b0;
    logic [7:0] chip_byte = 8'h00;
    wire  [7:0] bus;

    assign bus = chip_drv ? chip_byte : 8'hzz;

    usb_fifo_loopback #(.DATA_W(8), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n), .txe_n(txe_n),
        .oe_n(oe_n), .rd_n(rd_n), .wr_n(wr_n), .siwu_n(siwu_n), .data(bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    logic [7:0] host_q[$];
    logic [7:0] exp_q[$];
    int occ = 0;
    int rx_stall = 0, tx_stall = 0;
    bit tx_block = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input int i);
        return 8'((i * 37 + 5) ^ (i >> 3));
    endfunction

    function automatic bit stall(input int pct);
        return ($urandom_range(0, 99) < pct);
    endfunction

    task automatic send(input int n, input int base);
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            host_q.push_back(pat_byte(base + i));
            exp_q.push_back(pat_byte(base + i));
        end
    endtask

    task automatic drain(input string req);
        int waited = 0;
        while ((exp_q.size() != 0) && (waited < 5000)) begin
            @(posedge clk);
            waited++;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // chip model and per-cycle protocol checks
    initial begin
        bit pend_rd = 0, pend_wr = 0, rd_rose = 0;
        logic [7:0] wr_byte = 8'h00;
        logic p_rd_n = 1, p_oe_n = 1, p_wr_n = 1, p_rxf = 1, p_txe = 1;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (pend_rd) begin
                void'(host_q.pop_front());
                occ++;
            end
            if (pend_wr) begin
                if (exp_q.size() == 0) check(1'b0, "R6 extra byte", wr_byte, 0);
                else begin
                    check(wr_byte == exp_q[0], "R6 order", wr_byte, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                occ--;
            end
            check(siwu_n == 1'b1, "R1 siwu", siwu_n, 1);
            if (!rd_n) check(!oe_n, "R2 rd inside oe", oe_n, 0);
            if (!rd_n && p_rd_n) check(!p_oe_n, "R2 oe lead", p_oe_n, 0);
            if (!p_rd_n && p_rxf) check(rd_n && !oe_n, "R3 rxf stop", {rd_n, oe_n}, 2);
            if (rd_rose) check(oe_n, "R3 oe release", oe_n, 1);
            if (!p_wr_n && p_txe) check(wr_n, "R4 txe stop", wr_n, 1);
            check(!(!oe_n && !wr_n), "R5 oe/wr overlap", {oe_n, wr_n}, 3);
            check(occ <= DEPTH, "R7 occupancy", occ, DEPTH);
            if (occ == DEPTH) check(rd_n, "R7 full stops read", rd_n, 1);
            if (!wr_n && p_wr_n)
                check(p_oe_n && !p_txe && (p_rxf || occ == DEPTH) && occ > 0,
                      "R8 write start", {p_oe_n, p_txe, p_rxf}, 3'b101);
            if (!p_wr_n && !p_txe && occ == 0) check(wr_n, "R9 empty stop", wr_n, 1);
            if (!wr_n) check(occ > 0, "R9 write nonempty", occ, 1);

            wr_byte = bus;
            rxf_n = (host_q.size() == 0) || stall(rx_stall);
            txe_n = tx_block || stall(tx_stall);
            chip_drv = !oe_n;
            chip_byte = (host_q.size() != 0) ? host_q[0] : 8'h00;
            pend_rd = !rxf_n && !rd_n;
            pend_wr = !txe_n && !wr_n;
            rd_rose = !p_rd_n && rd_n;
            p_rd_n = rd_n; p_oe_n = oe_n; p_wr_n = wr_n; p_rxf = rxf_n; p_txe = txe_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        check(oe_n, "R1 reset oe_n", oe_n, 1);
        check(rd_n, "R1 reset rd_n", rd_n, 1);
        check(wr_n, "R1 reset wr_n", wr_n, 1);
        check(siwu_n, "R1 reset siwu_n", siwu_n, 1);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // directed: clean burst
        send(8, 0);
        drain("R6 clean burst");

        // directed: back-pressure fills the buffer
        tx_block = 1'b1;
        send(40, 100);
        repeat (150) @(posedge clk);
        check(occ == DEPTH, "R7 buffer full", occ, DEPTH);
        check(host_q.size() == 40 - DEPTH, "R7 reading stopped", host_q.size(), 40 - DEPTH);
        tx_block = 1'b0;
        drain("R6 full drain");

        // directed: single byte
        send(1, 300);
        drain("R9 single byte");

        // directed: heavy transmit stalls
        tx_stall = 70;
        send(24, 400);
        drain("R4 stalled writes");
        tx_stall = 0;

        // random rounds
        for (int r = 0; r < 10; r++) begin
            rx_stall = $urandom_range(0, 60);
            tx_stall = $urandom_range(0, 60);
            send($urandom_range(1, 60), 1000 + r * 64);
            drain("R3 random round");
        end

        // overlapping arrivals while returning
        rx_stall = 20;
        tx_stall = 20;
        send(20, 2000);
        repeat (10) @(posedge clk);
        send(20, 2020);
        drain("R6 overlap");

        repeat (10) @(posedge clk);
        check(occ == 0, "R6 final occupancy", occ, 0);
        check(host_q.size() == 0, "R6 host drained", host_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule